// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector with Spike Filter

This block sits between the pads of a two-wire serial bus and a slave state machine that runs on a fast system clock. Each raw line, clock and data, goes through a two-flop synchroniser and then a hold counter. The counter moves the filtered level to a new value only after that value has stayed the same for a set number of system clocks. Pulses shorter than the suppression time therefore never reach the filtered levels. The number of clocks is worked out at elaboration from the system clock period and the chosen speed grade. The slow grade rejects spikes below 50 ns and the fast grade rejects spikes below 40 ns.

From the filtered levels the block makes one-cycle strobes for the slave:
- start: data falls while the clock stays high.
- stop: data rises while the clock stays high.
- clock rising edge: the point to take in a data bit.
- clock falling edge: the point to drive the next output bit.

A separate strobe marks the case where both lines change in the same filtered cycle. In that case the order of the two changes cannot be known, so no start or stop is reported. A registered busy flag is set by a start and cleared by a stop. Byte framing and acknowledge handling belong to the slave behind this block.

Top module: `twi_cond_detect`

## Requirements
- R1: A raw level change that stays on the input for fewer than N system clock cycles does not change `scl_flt` or `sda_flt`, and causes no strobe.
- R2: A raw level change that stays for N or more cycles is accepted. The filtered level and its strobe appear in the cycle that begins N+1 rising clock edges after the edge that first samples the new raw level. Each strobe is high for exactly one cycle.
- R3: N is the suppression time divided by `CLK_PERIOD_PS`, rounded up, with a minimum of 1. The suppression time is 50 ns when `FAST_GRADE` = 0 and 40 ns when `FAST_GRADE` = 1.
- R4: `start_stb` pulses when filtered data goes from 1 to 0 while filtered clock is 1 both before and after the change.
- R5: `stop_stb` pulses when filtered data goes from 0 to 1 while filtered clock is 1 both before and after the change.
- R6: `scl_rise_stb` pulses once for each 0-to-1 change of filtered clock. `scl_fall_stb` pulses once for each 1-to-0 change.
- R7: In any cycle at most one of `start_stb`, `stop_stb`, `scl_rise_stb` and `scl_fall_stb` is high. A data change while clock is high is reported as start or stop, never as a sample strobe.
- R8: When both filtered lines change in the same cycle, `skew_stb` pulses, neither start nor stop is reported, and the clock edge strobe still fires.
- R9: `bus_busy` becomes 1 the cycle after a start and 0 the cycle after a stop. Otherwise it holds its value.
- R10: While `rst_n` is low, and right after it is released, both filtered levels are 1, all strobes are 0 and `bus_busy` is 0. This holds even if the bus was busy before reset.
- R11: A data change while filtered clock stays low produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line |
| scl_flt | output | 1 | Filtered clock level |
| sda_flt | output | 1 | Filtered data level |
| start_stb | output | 1 | Start condition strobe |
| stop_stb | output | 1 | Stop condition strobe |
| scl_rise_stb | output | 1 | Filtered clock rising edge (sample data) |
| scl_fall_stb | output | 1 | Filtered clock falling edge (change output) |
| skew_stb | output | 1 | Both lines changed in one filtered cycle |
| bus_busy | output | 1 | Set by start, cleared by stop |

## Verification
The main patterns are a full framed transfer and data moving while the clock is low. These tell the start/stop classification apart from the edge strobes. Pulses of N-1 cycles and of exactly N cycles find the exact acceptance edge of the filter. A second instance built for the fast grade receives the same four-cycle pulse, which shows that the grade parameter changes N. Steps where both lines switch together separate the skew case from a real start or stop. One timed edge fixes the exact latency from input to strobe.

// File: rtl/twi_cond_detect.sv
module twi_cond_detect #(
  parameter int CLK_PERIOD_PS = 10000,
  parameter bit FAST_GRADE    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_flt,
  output logic sda_flt,
  output logic start_stb,
  output logic stop_stb,
  output logic scl_rise_stb,
  output logic scl_fall_stb,
  output logic skew_stb,
  output logic bus_busy
);

  // R3
  localparam int SUPP_PS = FAST_GRADE ? 40000 : 50000;
  localparam int RAW_N   = (SUPP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int FILT_N  = (RAW_N < 1) ? 1 : RAW_N;
  localparam int CW      = $clog2(FILT_N + 1);

  logic [1:0] raw;
  logic [1:0] synced;
  logic [1:0] flt;
  logic [1:0] flt_d;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic meta, sync_q, lvl;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b1;
        sync_q <= 1'b1;
        lvl    <= 1'b1;
        cnt    <= '0;
      end else begin
        meta   <= raw[g];
        sync_q <= meta;
        if (sync_q == lvl) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_N - 1)) begin
          lvl <= sync_q;
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign synced[g] = sync_q;
    assign flt[g]    = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_d <= 2'b11;
    else        flt_d <= flt;
  end

  logic scl_now, scl_was, sda_now, sda_was;
  assign scl_now = flt[1];
  assign scl_was = flt_d[1];
  assign sda_now = flt[0];
  assign sda_was = flt_d[0];

  assign scl_flt      = scl_now;
  assign sda_flt      = sda_now;
  assign start_stb    = scl_now & scl_was & sda_was & ~sda_now;
  assign stop_stb     = scl_now & scl_was & ~sda_was & sda_now;
  assign scl_rise_stb = scl_now & ~scl_was;
  assign scl_fall_stb = ~scl_now & scl_was;
  assign skew_stb     = (scl_now ^ scl_was) & (sda_now ^ sda_was);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bus_busy <= 1'b0;
    else if (start_stb) bus_busy <= 1'b1;
    else if (stop_stb)  bus_busy <= 1'b0;
  end

  // R1
  scl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_flt) |-> $past(synced[1]) == scl_flt);

  // R1
  sda_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_flt) |-> $past(synced[0]) == sda_flt);

  // R4
  start_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |-> (scl_flt && !sda_flt));

  // R5
  stop_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |-> (scl_flt && sda_flt));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_stb, stop_stb, scl_rise_stb, scl_fall_stb}));

  // R8
  skew_nocond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skew_stb |-> (!start_stb && !stop_stb));

  // R9
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> bus_busy);

  // R9
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> !bus_busy);

endmodule

// File: tb/twi_cond_detect_tb.sv
module twi_cond_detect_tb;
  localparam int CLK_NS  = 10;
  localparam int EXP_N   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic scl_flt, sda_flt, start_stb, stop_stb, scl_rise_stb, scl_fall_stb, skew_stb, bus_busy;
  logic f_scl, f_sda, f_start, f_stop, f_rise, f_fall, f_skew, f_busy;

  int checks = 0, errors = 0;
  int n_start, n_stop, n_rise, n_fall, n_skew, fast_start;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  twi_cond_detect #(.CLK_PERIOD_PS(CLK_NS*1000), .FAST_GRADE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_flt(scl_flt), .sda_flt(sda_flt), .start_stb(start_stb), .stop_stb(stop_stb),
    .scl_rise_stb(scl_rise_stb), .scl_fall_stb(scl_fall_stb), .skew_stb(skew_stb),
    .bus_busy(bus_busy));

  twi_cond_detect #(.CLK_PERIOD_PS(CLK_NS*1000), .FAST_GRADE(1'b1)) u_fast (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_flt(f_scl), .sda_flt(f_sda), .start_stb(f_start), .stop_stb(f_stop),
    .scl_rise_stb(f_rise), .scl_fall_stb(f_fall), .skew_stb(f_skew),
    .bus_busy(f_busy));

  // {scl, sda, hold[7:0], start, stop, rise, fall, skew, busy, fscl, fsda}
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd10, 8'b1000_0110},
    {1'b0, 1'b0, 8'd10, 8'b0001_0100},
    {1'b0, 1'b1, 8'd10, 8'b0000_0101},
    {1'b1, 1'b1, 8'd10, 8'b0010_0111},
    {1'b0, 1'b1, 8'd10, 8'b0001_0101},
    {1'b0, 1'b0, 8'd10, 8'b0000_0100},
    {1'b1, 1'b0, 8'd3,  8'b0000_0100},
    {1'b0, 1'b0, 8'd10, 8'b0000_0100},
    {1'b1, 1'b0, 8'd10, 8'b0010_0110},
    {1'b1, 1'b1, 8'd4,  8'b0000_0110},
    {1'b1, 1'b0, 8'd10, 8'b0000_0110},
    {1'b1, 1'b1, 8'd10, 8'b0100_0011},
    {1'b0, 1'b0, 8'd10, 8'b0001_1000},
    {1'b1, 1'b1, 8'd10, 8'b0010_1011},
    {1'b1, 1'b0, 8'd10, 8'b1000_0110},
    {1'b1, 1'b1, 8'd10, 8'b0100_0011}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_step(input logic s, input logic d, input int hold);
    n_start = 0; n_stop = 0; n_rise = 0; n_fall = 0; n_skew = 0; fast_start = 0;
    scl_in = s; sda_in = d;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      n_start += int'(start_stb); n_stop += int'(stop_stb);
      n_rise += int'(scl_rise_stb); n_fall += int'(scl_fall_stb);
      n_skew += int'(skew_stb); fast_start += int'(f_start);
    end
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "scl_flt in reset", int'(scl_flt), 1);
    check("R10", "sda_flt in reset", int'(sda_flt), 1);
    check("R10", "strobes in reset", int'({start_stb, stop_stb, scl_rise_stb, scl_fall_stb, skew_stb}), 0);
    check("R10", "busy in reset", int'(bus_busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R1 R4 R5 R6 R7 R8 R9 R11
    for (int v = 0; v < NV; v++) begin
      logic [17:0] e;
      e = VEC[v];
      run_step(e[17], e[16], int'(e[15:8]));
      check("R4", $sformatf("step %0d start count", v), n_start, int'(e[7]));
      check("R5", $sformatf("step %0d stop count", v), n_stop, int'(e[6]));
      check("R6", $sformatf("step %0d rise count", v), n_rise, int'(e[5]));
      check("R6", $sformatf("step %0d fall count", v), n_fall, int'(e[4]));
      check("R8", $sformatf("step %0d skew count", v), n_skew, int'(e[3]));
      check("R9", $sformatf("step %0d busy", v), int'(bus_busy), int'(e[2]));
      check("R1", $sformatf("step %0d scl_flt", v), int'(scl_flt), int'(e[1]));
      check("R1", $sformatf("step %0d sda_flt", v), int'(sda_flt), int'(e[0]));
    end

    // R2 exact latency, idle (1,1) to data low
    sda_in = 1'b0;
    for (int m = 1; m <= EXP_N + 3; m++) begin
      @(negedge clk);
      if (m == EXP_N + 1) begin
        check("R2", "start before latency", int'(start_stb), 0);
        check("R2", "sda_flt before latency", int'(sda_flt), 1);
      end
      if (m == EXP_N + 2) begin
        check("R2", "start at latency", int'(start_stb), 1);
        check("R2", "sda_flt at latency", int'(sda_flt), 0);
      end
      if (m == EXP_N + 3) check("R2", "start one cycle only", int'(start_stb), 0);
    end
    run_step(1'b1, 1'b1, 12);
    check("R5", "stop after latency test", n_stop, 1);

    // R2 pulse of exactly N cycles is accepted
    run_step(1'b1, 1'b0, EXP_N);
    begin
      int st;
      st = n_start;
      run_step(1'b1, 1'b1, 12);
      check("R2", "N-cycle pulse start", st + n_start, 1);
      check("R2", "N-cycle pulse stop", n_stop, 1);
    end

    // R3 four-cycle pulse: rejected at 50 ns, accepted at 40 ns
    run_step(1'b1, 1'b0, 4);
    begin
      int fs;
      fs = fast_start;
      run_step(1'b1, 1'b1, 12);
      check("R3", "slow grade 4-cycle start", n_start, 0);
      check("R3", "fast grade 4-cycle start", fs + fast_start, 1);
      check("R3", "slow grade busy", int'(bus_busy), 0);
    end

    // R10 reset while busy
    run_step(1'b1, 1'b0, 10);
    check("R9", "busy before reset", int'(bus_busy), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "busy cleared by reset", int'(bus_busy), 0);
    check("R10", "sda_flt after reset", int'(sda_flt), 1);
    scl_in = 1'b1; sda_in = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    run_step(1'b1, 1'b1, 10);
    check("R10", "no strobe after reset", n_start + n_stop + n_rise + n_fall, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule